// File: doc/BRIEF.md
# Register-Value Correlated Branch Override Predictor

This block works beside a simple direction predictor and can overrule it. A small tagless table is indexed by a hash of the branch address and the live values of up to four operand registers that the branch depends on. The table learns only from the base predictor's mistakes. When a branch resolves against the base guess, the outcome is stored at the hashed slot and the slot is marked valid. Later, a lookup with the same address and register values hits that slot, and the stored direction replaces the base guess.

The base predictor is included so the block is self-contained. It is a table of 2-bit saturating counters indexed by the branch address. Lookup is fully combinational. Updates take effect at the rising clock edge. The caller resolves branches and reports whether the base guess was wrong. Deciding which registers belong to a branch is done outside the block, which receives the values and a per-slot enable mask.

Top module: `regval_override_pred`

## Requirements
- R1: After the asynchronous active-low reset, no override slot is valid (hit_o = 0), and every base counter holds 01, so the base guess is not-taken.
- R2: Each base counter is a 2-bit saturating counter at index pc[BASE_W+1:2]. It increments on a taken update, decrements on a not-taken update, and saturates at 11 and 00. The base guess is taken when bit 1 is set.
- R3: Every update with up_valid_i = 1 trains the base counter, whatever up_base_wrong_i says.
- R4: The override index is pc[IDX_W+1:2] XOR the fold of each enabled register. The fold of a value is the XOR of its IDX_W-bit slices, starting at bit 0, with the top slice zero-padded.
- R5: An update with up_valid_i = 1 and up_base_wrong_i = 1 marks the hashed slot valid and stores up_taken_i in it.
- R6: An update with up_base_wrong_i = 0 leaves the override table unchanged.
- R7: On a valid slot, hit_o = 1 and final_taken_o is the stored direction. Otherwise hit_o = 0 and final_taken_o equals base_taken_o.
- R8: When a lookup and an update touch the same slot in the same cycle, the lookup returns the contents from before the update.
- R9: A register slot whose enable bit is 0 has no effect on the index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lk_pc_i | input | PC_W | Lookup branch address |
| lk_regs_i | input | NREG*DATA_W | Lookup register values, slot k at bits [k*DATA_W +: DATA_W] |
| lk_reg_en_i | input | NREG | Lookup register slot enables |
| base_taken_o | output | 1 | Base counter guess |
| final_taken_o | output | 1 | Final direction after override |
| hit_o | output | 1 | Override slot was valid and used |
| up_valid_i | input | 1 | Resolved branch update strobe |
| up_pc_i | input | PC_W | Update branch address |
| up_regs_i | input | NREG*DATA_W | Update register values |
| up_reg_en_i | input | NREG | Update register slot enables |
| up_taken_i | input | 1 | Resolved direction |
| up_base_wrong_i | input | 1 | Base predictor mispredicted this branch |

## Verification
The bench targets same-cycle read and write on one slot. A design that forwarded the new entry would report a hit one cycle early. It also checks the counter limits, where a counter that wraps would flip the base guess after a run of equal outcomes. Masked register slots are given values that differ between training and lookup, so a design that hashed disabled slots would miss. Updates with a correct base guess are followed by lookups at the same slot, which catches a table that learns on every branch.

// File: rtl/rvop_pkg.sv
package rvop_pkg;
  typedef logic [1:0] ctr_t;
  localparam ctr_t CTR_SNT = 2'b00;
  localparam ctr_t CTR_WNT = 2'b01;
  localparam ctr_t CTR_ST  = 2'b11;
endpackage

// File: rtl/rvop_hash.sv
module rvop_hash #(
  parameter int PC_W   = 32,
  parameter int DATA_W = 32,
  parameter int NREG   = 4,
  parameter int IDX_W  = 10
) (
  input  logic [PC_W-1:0]        pc_i,
  input  logic [NREG*DATA_W-1:0] regs_i,
  input  logic [NREG-1:0]        reg_en_i,
  output logic [IDX_W-1:0]       idx_o
);
  // each register bit lands on lane (bit mod IDX_W): equals XOR of its slices
  always_comb begin
    idx_o = pc_i[IDX_W+1:2];
    for (int k = 0; k < NREG; k++) begin
      for (int b = 0; b < DATA_W; b++) begin
        if (reg_en_i[k]) idx_o[b % IDX_W] = idx_o[b % IDX_W] ^ regs_i[k*DATA_W + b];
      end
    end
  end
endmodule

// File: rtl/rvop_base.sv
module rvop_base
  import rvop_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int BASE_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] lk_pc_i,
  output logic            taken_o,
  input  logic            up_valid_i,
  input  logic [PC_W-1:0] up_pc_i,
  input  logic            up_taken_i
);
  localparam int DEPTH = 1 << BASE_W;

  ctr_t              cnt_q [DEPTH];
  logic [BASE_W-1:0] lk_idx, up_idx;

  assign lk_idx  = lk_pc_i[BASE_W+1:2];
  assign up_idx  = up_pc_i[BASE_W+1:2];
  assign taken_o = cnt_q[lk_idx][1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) cnt_q[i] <= CTR_WNT;
    end else if (up_valid_i) begin
      if (up_taken_i && cnt_q[up_idx] != CTR_ST) cnt_q[up_idx] <= cnt_q[up_idx] + 2'd1;
      else if (!up_taken_i && cnt_q[up_idx] != CTR_SNT) cnt_q[up_idx] <= cnt_q[up_idx] - 2'd1;
    end
  end

  assert_sat_high_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_valid_i && up_taken_i && cnt_q[up_idx] == CTR_ST) |=> cnt_q[$past(up_idx)] == CTR_ST);
  assert_sat_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_valid_i && !up_taken_i && cnt_q[up_idx] == CTR_SNT) |=> cnt_q[$past(up_idx)] == CTR_SNT);
endmodule

// File: rtl/rvop_table.sv
module rvop_table #(
  parameter int IDX_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] lk_idx_i,
  output logic             hit_o,
  output logic             dir_o,
  input  logic             we_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_dir_i
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0] valid_q, dir_q;

  // read sees pre-edge contents, so same-slot read/write returns old data
  assign hit_o = valid_q[lk_idx_i];
  assign dir_o = dir_q[lk_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dir_q   <= '0;
    end else if (we_i) begin
      valid_q[wr_idx_i] <= 1'b1;
      dir_q[wr_idx_i]   <= wr_dir_i;
    end
  end

  assert_write_lands_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (valid_q[$past(wr_idx_i)] && dir_q[$past(wr_idx_i)] == $past(wr_dir_i)));
  assert_no_write_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(valid_q) && $stable(dir_q)));
endmodule

// File: rtl/regval_override_pred.sv
module regval_override_pred #(
  parameter int PC_W   = 32,
  parameter int DATA_W = 32,
  parameter int NREG   = 4,
  parameter int IDX_W  = 10,
  parameter int BASE_W = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [PC_W-1:0]        lk_pc_i,
  input  logic [NREG*DATA_W-1:0] lk_regs_i,
  input  logic [NREG-1:0]        lk_reg_en_i,
  output logic                   base_taken_o,
  output logic                   final_taken_o,
  output logic                   hit_o,
  input  logic                   up_valid_i,
  input  logic [PC_W-1:0]        up_pc_i,
  input  logic [NREG*DATA_W-1:0] up_regs_i,
  input  logic [NREG-1:0]        up_reg_en_i,
  input  logic                   up_taken_i,
  input  logic                   up_base_wrong_i
);
  logic [IDX_W-1:0] lk_idx, up_idx;
  logic             tbl_dir, tbl_we;

  rvop_hash #(.PC_W(PC_W), .DATA_W(DATA_W), .NREG(NREG), .IDX_W(IDX_W)) u_lk_hash (
    .pc_i(lk_pc_i), .regs_i(lk_regs_i), .reg_en_i(lk_reg_en_i), .idx_o(lk_idx));

  rvop_hash #(.PC_W(PC_W), .DATA_W(DATA_W), .NREG(NREG), .IDX_W(IDX_W)) u_up_hash (
    .pc_i(up_pc_i), .regs_i(up_regs_i), .reg_en_i(up_reg_en_i), .idx_o(up_idx));

  rvop_base #(.PC_W(PC_W), .BASE_W(BASE_W)) u_base (
    .clk_i, .rst_ni, .lk_pc_i, .taken_o(base_taken_o),
    .up_valid_i, .up_pc_i, .up_taken_i);

  assign tbl_we = up_valid_i && up_base_wrong_i;

  rvop_table #(.IDX_W(IDX_W)) u_table (
    .clk_i, .rst_ni, .lk_idx_i(lk_idx), .hit_o, .dir_o(tbl_dir),
    .we_i(tbl_we), .wr_idx_i(up_idx), .wr_dir_i(up_taken_i));

  assign final_taken_o = hit_o ? tbl_dir : base_taken_o;
endmodule

// File: tb/regval_override_pred_bench.sv
`timescale 1ns/1ps
module regval_override_pred_bench;
  localparam int PC_W = 32, DATA_W = 32, NREG = 4, IDX_W = 10, BASE_W = 8;

  logic clk = 0, rst_ni = 0;
  logic [PC_W-1:0] lk_pc, up_pc;
  logic [NREG*DATA_W-1:0] lk_regs, up_regs;
  logic [NREG-1:0] lk_en, up_en;
  logic up_valid, up_taken, up_wrong;
  logic base_taken, final_taken, hit;

  always #2.5 clk = ~clk;

  regval_override_pred u_regval_override_pred (
    .clk_i(clk), .rst_ni(rst_ni), .lk_pc_i(lk_pc), .lk_regs_i(lk_regs), .lk_reg_en_i(lk_en),
    .base_taken_o(base_taken), .final_taken_o(final_taken), .hit_o(hit),
    .up_valid_i(up_valid), .up_pc_i(up_pc), .up_regs_i(up_regs), .up_reg_en_i(up_en),
    .up_taken_i(up_taken), .up_base_wrong_i(up_wrong));

  int vectors = 0, miscompares = 0;
  bit done = 0;
  bit mv [1<<IDX_W];
  bit md [1<<IDX_W];
  int mc [1<<BASE_W];

  function automatic int hash_ref(logic [PC_W-1:0] pc, logic [NREG*DATA_W-1:0] r, logic [NREG-1:0] en);
    longint h = longint'(pc >> 2) & ((64'd1 << IDX_W) - 1);
    for (int k = 0; k < NREG; k++) begin
      longint v = longint'(r[k*DATA_W +: DATA_W]);
      if (!en[k]) continue;
      for (int s = 0; s * IDX_W < DATA_W; s++) h ^= (v >> (s * IDX_W)) & ((64'd1 << IDX_W) - 1);
    end
    return int'(h);
  endfunction

  function automatic int bidx(logic [PC_W-1:0] pc);
    return int'((pc >> 2) & ((1 << BASE_W) - 1));
  endfunction

  function automatic bit base_ref(logic [PC_W-1:0] pc);
    return mc[bidx(pc)] >= 2;
  endfunction

  task automatic check(string req, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_lookup(string req);
    int i = hash_ref(lk_pc, lk_regs, lk_en);
    bit eb = base_ref(lk_pc);
    check({req, " R2 base"}, base_taken, eb);
    check({req, " R7 hit"}, hit, mv[i]);
    check({req, " R7 final"}, final_taken, mv[i] ? md[i] : eb);
  endtask

  task automatic model_edge();
    if (up_valid) begin
      int b = bidx(up_pc);
      if (up_taken && mc[b] < 3) mc[b]++;
      else if (!up_taken && mc[b] > 0) mc[b]--;
      if (up_wrong) begin
        mv[hash_ref(up_pc, up_regs, up_en)] = 1;
        md[hash_ref(up_pc, up_regs, up_en)] = up_taken;
      end
    end
  endtask

  // drive on negedge, check before posedge, then advance the model
  task automatic step(string req);
    #1;
    check_lookup(req);
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic idle_up();
    up_valid = 0; up_wrong = 0; up_taken = 0; up_pc = '0; up_regs = '0; up_en = '0;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      miscompares++; vectors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < (1<<IDX_W); i++) begin mv[i] = 0; md[i] = 0; end
    for (int i = 0; i < (1<<BASE_W); i++) mc[i] = 1;
    lk_pc = 32'h100; lk_regs = '0; lk_en = '0;
    idle_up();
    repeat (3) @(negedge clk);
    // R1 reset state, checked while reset held and after release
    #1; check("R1 reset hit", hit, 1'b0); check("R1 reset base", base_taken, 1'b0);
    rst_ni = 1;
    @(negedge clk);
    step("R1");

    // R2/R3: drive one counter up past saturation and back below, with base_wrong tagged
    lk_pc = 32'h0000_0040; lk_regs = {4{32'hAAAA_0001}}; lk_en = 4'b0000;
    for (int n = 0; n < 5; n++) begin
      up_valid = 1; up_pc = 32'h40; up_taken = 1; up_wrong = 0; up_en = '0; up_regs = '0;
      step("R3 R2 up");
    end
    idle_up(); step("R2 sat high");
    check("R2 sat high", base_taken, 1'b1);
    for (int n = 0; n < 5; n++) begin
      up_valid = 1; up_pc = 32'h40; up_taken = 0; up_wrong = 1; up_regs = {4{32'h7}}; up_en = 4'hF;
      step("R3 R2 down");
    end
    idle_up(); step("R2 sat low");
    check("R2 sat low", base_taken, 1'b0);

    // R6: correct base prediction must not train the table
    lk_pc = 32'h0000_2000; lk_regs = {32'h0, 32'h0, 32'h0, 32'h1234}; lk_en = 4'b0001;
    up_valid = 1; up_pc = lk_pc; up_regs = lk_regs; up_en = lk_en; up_taken = 0; up_wrong = 0;
    step("R6 write");
    idle_up(); step("R6 after");
    check("R6 no hit", hit, 1'b0);

    // R8: same-slot lookup and write in one cycle returns old contents
    up_valid = 1; up_pc = lk_pc; up_regs = lk_regs; up_en = lk_en; up_taken = 1; up_wrong = 1;
    #1; check("R8 same cycle miss", hit, 1'b0);
    step("R8");
    idle_up(); step("R5 R8 next");
    check("R5 hit", hit, 1'b1); check("R5 dir", final_taken, 1'b1);
    up_valid = 1; up_pc = lk_pc; up_regs = lk_regs; up_en = lk_en; up_taken = 0; up_wrong = 1;
    #1; check("R8 old dir", final_taken, 1'b1);
    step("R8 overwrite");
    idle_up(); step("R5 new dir");
    check("R5 new dir", final_taken, 1'b0);

    // R9: disabled slots differ between training and lookup yet still hit
    up_valid = 1; up_pc = 32'h0000_3004; up_en = 4'b0101; up_taken = 1; up_wrong = 1;
    up_regs = {32'hDEAD_BEEF, 32'h0000_0321, 32'h1111_2222, 32'h0000_0F0F};
    lk_pc = 32'h0;
    step("R9 train");
    idle_up();
    lk_pc = 32'h0000_3004; lk_en = 4'b0101;
    lk_regs = {32'h0BAD_F00D, 32'h0000_0321, 32'h9999_8888, 32'h0000_0F0F};
    step("R9 lookup");
    check("R9 masked hit", hit, 1'b1);
    // R4: enabling a slot changes the index as the fold predicts
    lk_en = 4'b1101;
    step("R4 fold");

    // random mix, small value pools for collisions
    for (int n = 0; n < 4000; n++) begin
      lk_pc = {$urandom_range(0, 63), 2'b00} | 32'h4000;
      for (int k = 0; k < NREG; k++) lk_regs[k*DATA_W +: DATA_W] = $urandom_range(0, 3) << ($urandom_range(0, 3) * 10);
      lk_en = 4'($urandom);
      up_valid = 1'($urandom);
      if ($urandom_range(0, 1) == 1) begin
        up_pc = lk_pc; up_regs = lk_regs; up_en = lk_en;
      end else begin
        up_pc = {$urandom_range(0, 63), 2'b00} | 32'h4000;
        for (int k = 0; k < NREG; k++) up_regs[k*DATA_W +: DATA_W] = $urandom_range(0, 3);
        up_en = 4'($urandom);
      end
      up_taken = 1'($urandom);
      up_wrong = (base_ref(up_pc) != up_taken);
      step("R4 R7 random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule